// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This block supervises the high-side switch of each channel in a multi-phase switching regulator. An analog comparator reports when the sensed switch-node level falls below the programmed current threshold. The block only acts on that report while its own high-side drive is on. When it sees overcurrent, it turns the drive off for the rest of that switching period. This is pulse-by-pulse limiting.

A run of consecutive limited periods means a hard fault. Once soft-start has finished, such a run forces a hiccup restart. The soft-start level is pulled to zero and held there for a fixed discharge time. It is then ramped up again. The output stays disabled until the ramp passes an enable threshold. While the ramp is running, the run counter is held at zero, so a short that persists gives a repeating retry loop rather than a permanent shutdown. If the short goes away, the next ramp completes, and the channel returns to normal operation with its hiccup indication cleared.

Each channel has its own copy of the protection. The channels share one period-start strobe. Channel k starts its period `PHASE_STEP*k` clock cycles after that strobe, so with two channels and a strobe every `2*PHASE_STEP` cycles the channels run half a period apart.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While `rst` is high, every channel drives `hs_gate`, `out_en` and `hiccup` low and its soft-start level is 0.
- R2: On its period strobe, a channel's `hs_gate` goes high on the next clock if `out_en` is high and its `pwm_req` is high. During the period, `hs_gate` drops on the clock after `pwm_req` goes low.
- R3: If `hs_gate` is high and `oc_cmp` is high in a cycle that is not a period strobe, `hs_gate` is low from the next clock until the next period strobe. This holds during soft-start as well.
- R4: `oc_cmp` has no effect while the channel's `hs_gate` is low. Overcurrent reported only when the drive is off never leads to a hiccup.
- R5: A period counts as an overcurrent period if the drive was cut in it. After soft-start is complete, the 32nd consecutive overcurrent period, evaluated at the strobe that ends it, starts a hiccup (`CNT_LIMIT` = 32). On that same clock `hiccup` goes high, the soft-start level goes to 0, and `out_en` and `hs_gate` go low.
- R6: A period without overcurrent sets the consecutive count back to zero.
- R7: While soft-start is incomplete the count stays at zero. After a hiccup with the fault still present, the next hiccup occurs at the 32nd strobe after the ramp completes.
- R8: Soft-start behaves as follows. After reset release, or after a hiccup discharge of `DISCH_CYC` cycles, the level rises by one every `SS_DIV` clocks. `out_en` is high exactly when the level is at least `SS_TRIP`. The level stops at `SS_TOP`, which marks completion. With the defaults, the level reaches 8 with `out_en` high at clock 16 after release, and reaches 32 at clock 64.
- R9: `hiccup` goes low on the clock where the restart ramp reaches `SS_TOP`. If the fault has gone, it stays low.
- R10: Channels are independent. A fault or hiccup on one leaves the other's outputs unaffected. Channel 1's period strobe comes `PHASE_STEP` clocks after `cyc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Period-start strobe for channel 0; later channels are offset from it |
| pwm_req | input | NCH | Per-channel high-side on request from the modulator |
| oc_cmp | input | NCH | Per-channel overcurrent comparator output |
| hs_gate | output | NCH | Registered high-side drive per channel |
| ss_level | output | NCH*SS_W | Soft-start level per channel, channel k in bits [k*SS_W +: SS_W] |
| out_en | output | NCH | Output enabled (level at or above the enable threshold) |
| hiccup | output | NCH | Hiccup restart in progress |

## Verification
All outputs are registered. A change in drive, enable or level shows up just after the clock edge that samples the stimulus. The bench therefore drives and samples a short delay after each rising edge.

The pulse cut appears one clock after the drive and the comparator are both high. A hiccup appears right after the strobe edge that ends the 32nd overcurrent period. The bench counts those strobe edges itself and checks the flag one strobe before and exactly at the trigger.

Ramp timing is checked by clock counts measured from the triggering edge: the discharge takes 6 clocks, each level step takes 2 clocks, the enable comes on at 22 clocks, and completion comes at 70 clocks. The count is checked both sides of each threshold.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    SS_DISCH = 2'd0,
    SS_RAMP  = 2'd1,
    SS_DONE  = 2'd2
  } ss_state_t;
endpackage

// File: rtl/ocp_phase_split.sv
module ocp_phase_split #(
  parameter int NCH        = 2,
  parameter int PHASE_STEP = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cyc_start,
  output logic [NCH-1:0] strobe
);
  localparam int LAST = PHASE_STEP * (NCH - 1);
  localparam int PCW  = $clog2(LAST + 2);

  logic [PCW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
    end else if (cyc_start) begin
      pcnt <= PCW'(1);
    end else if (pcnt != '0 && pcnt != PCW'(LAST + 1)) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assign strobe[0] = cyc_start;

  for (genvar k = 1; k < NCH; k++) begin : g_lag
    assign strobe[k] = (pcnt == PCW'(PHASE_STEP * k));
  end

  // R10: the offset counter saturates and never wraps
  assert_pcnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    pcnt <= PCW'(LAST + 1));
endmodule

// File: rtl/ocp_softstart.sv
module ocp_softstart
  import ocp_pkg::*;
#(
  parameter int SS_W      = 8,
  parameter int SS_DIV    = 2,
  parameter int SS_TRIP   = 8,
  parameter int SS_TOP    = 32,
  parameter int DISCH_CYC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  output logic [SS_W-1:0] level,
  output logic            en,
  output logic            done,
  output logic            hiccup
);
  localparam int PW = $clog2(SS_DIV + 1);
  localparam int TW = $clog2(DISCH_CYC + 1);

  ss_state_t       st, st_d;
  logic [SS_W-1:0] lvl_d;
  logic [PW-1:0]   pre, pre_d;
  logic [TW-1:0]   tmr, tmr_d;
  logic            hic_d;

  always_comb begin
    st_d  = st;
    lvl_d = level;
    pre_d = pre;
    tmr_d = tmr;
    hic_d = hiccup;
    if (restart) begin
      st_d  = SS_DISCH;
      lvl_d = '0;
      pre_d = '0;
      tmr_d = TW'(DISCH_CYC - 1);
      hic_d = 1'b1;
    end else begin
      case (st)
        SS_DISCH: begin
          if (tmr == '0) st_d = SS_RAMP;
          else           tmr_d = tmr - 1'b1;
        end
        SS_RAMP: begin
          if (pre == PW'(SS_DIV - 1)) begin
            pre_d = '0;
            lvl_d = level + 1'b1;
            if (level == SS_W'(SS_TOP - 1)) begin
              st_d  = SS_DONE;
              hic_d = 1'b0;
            end
          end else begin
            pre_d = pre + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SS_RAMP;
      level  <= '0;
      pre    <= '0;
      tmr    <= '0;
      en     <= 1'b0;
      hiccup <= 1'b0;
    end else begin
      st     <= st_d;
      level  <= lvl_d;
      pre    <= pre_d;
      tmr    <= tmr_d;
      en     <= (lvl_d >= SS_W'(SS_TRIP));
      hiccup <= hic_d;
    end
  end

  assign done = (st == SS_DONE);

  assert_level_cap_R8: assert property (@(posedge clk) disable iff (rst)
    level <= SS_W'(SS_TOP));
  assert_ramp_step_R8: assert property (@(posedge clk) disable iff (rst)
    (st == SS_RAMP && !restart) |=> (level - $past(level)) <= SS_W'(1));
  assert_discharge_R5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (level == '0 && !en && hiccup));
  assert_hic_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(hiccup) |-> (st == SS_DONE && level == SS_W'(SS_TOP)));
endmodule

// File: rtl/ocp_pulse_guard.sv
module ocp_pulse_guard #(
  parameter int CNT_LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic pwm_req,
  input  logic oc_cmp,
  input  logic en,
  input  logic ss_done,
  output logic hs_gate,
  output logic trip
);
  localparam int CW = $clog2(CNT_LIMIT + 1);

  logic          on_q;
  logic          oc_seen;
  logic [CW-1:0] run_cnt;
  logic          cyc_oc;

  // overcurrent in the period now ending: already cut, or cut this cycle
  assign cyc_oc = oc_seen | (on_q & oc_cmp);
  assign trip   = strobe & ss_done & cyc_oc & (run_cnt == CW'(CNT_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= 1'b0;
      oc_seen <= 1'b0;
      run_cnt <= '0;
    end else begin
      if (strobe) begin
        oc_seen <= 1'b0;
        if (!ss_done || !cyc_oc || trip) run_cnt <= '0;
        else                             run_cnt <= run_cnt + 1'b1;
      end else if (on_q && oc_cmp) begin
        oc_seen <= 1'b1;
      end

      if (trip || !en)             on_q <= 1'b0;
      else if (strobe)             on_q <= pwm_req;
      else if (oc_cmp || !pwm_req) on_q <= 1'b0;
    end
  end

  assign hs_gate = on_q;

  assert_pulse_cut_R3: assert property (@(posedge clk) disable iff (rst)
    (on_q && oc_cmp && !strobe) |=> !on_q);
  assert_gate_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !on_q);
  assert_count_held_R7: assert property (@(posedge clk) disable iff (rst)
    !ss_done |=> run_cnt == '0);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    run_cnt < CW'(CNT_LIMIT));
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int NCH        = 2,
  parameter int PHASE_STEP = 8,
  parameter int CNT_LIMIT  = 32,
  parameter int SS_W       = 8,
  parameter int SS_DIV     = 2,
  parameter int SS_TRIP    = 8,
  parameter int SS_TOP     = 32,
  parameter int DISCH_CYC  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cyc_start,
  input  logic [NCH-1:0]      pwm_req,
  input  logic [NCH-1:0]      oc_cmp,
  output logic [NCH-1:0]      hs_gate,
  output logic [NCH*SS_W-1:0] ss_level,
  output logic [NCH-1:0]      out_en,
  output logic [NCH-1:0]      hiccup
);
  logic [NCH-1:0] strobe;
  logic [NCH-1:0] trip;
  logic [NCH-1:0] ss_done;

  ocp_phase_split #(.NCH(NCH), .PHASE_STEP(PHASE_STEP)) u_phase (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .strobe(strobe)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ocp_softstart #(
      .SS_W(SS_W), .SS_DIV(SS_DIV), .SS_TRIP(SS_TRIP),
      .SS_TOP(SS_TOP), .DISCH_CYC(DISCH_CYC)
    ) u_ss (
      .clk(clk), .rst(rst), .restart(trip[i]),
      .level(ss_level[i*SS_W +: SS_W]), .en(out_en[i]),
      .done(ss_done[i]), .hiccup(hiccup[i])
    );

    ocp_pulse_guard #(.CNT_LIMIT(CNT_LIMIT)) u_guard (
      .clk(clk), .rst(rst), .strobe(strobe[i]), .pwm_req(pwm_req[i]),
      .oc_cmp(oc_cmp[i]), .en(out_en[i]), .ss_done(ss_done[i]),
      .hs_gate(hs_gate[i]), .trip(trip[i])
    );

    assert_restart_clean_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(hiccup[i]) |-> (ss_level[i*SS_W +: SS_W] == '0 && !out_en[i] && !hs_gate[i]));
  end
endmodule

// File: tb/ocp_hiccup_ctrl_test.sv
module ocp_hiccup_ctrl_test;
  localparam int NCH = 2;
  localparam int SS_W = 8;
  localparam int PER = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0;
  logic [NCH-1:0] pwm_req = '0;
  logic [NCH-1:0] oc_cmp = '0;
  logic [NCH-1:0] hs_gate, out_en, hiccup;
  logic [NCH*SS_W-1:0] ss_level;
  logic gen_on = 1'b0;
  bit finished = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  ocp_hiccup_ctrl uut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .pwm_req(pwm_req),
    .oc_cmp(oc_cmp), .hs_gate(hs_gate), .ss_level(ss_level),
    .out_en(out_en), .hiccup(hiccup)
  );

  always #2.5 clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      if (gen_on) begin
        cyc_start = (ph == 0);
        ph = (ph + 1) % PER;
      end
    end
  end

  function automatic int lvl(input int ch);
    return int'(ss_level[ch*SS_W +: SS_W]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_s();
    forever begin
      @(posedge clk);
      if (cyc_start) break;
    end
    #2;
  endtask

  task automatic t_reset();
    ticks(5);
    chk(hs_gate == 0, "R1 gate", hs_gate, 0);
    chk(out_en == 0, "R1 enable", out_en, 0);
    chk(hiccup == 0, "R1 hiccup", hiccup, 0);
    chk(ss_level == 0, "R1 level", ss_level, 0);
  endtask

  task automatic t_powerup();
    gen_on = 1'b1;
    pwm_req = 2'b11;
    rst = 1'b0;
    ticks(15);
    chk(out_en[0] == 0, "R8 enable before trip", out_en[0], 0);
    chk(lvl(0) == 7, "R8 level clk15", lvl(0), 7);
    ticks(1);
    chk(out_en == 2'b11, "R8 enable at trip", out_en, 3);
    chk(lvl(1) == 8, "R8 level clk16", lvl(1), 8);
    ticks(48);
    chk(lvl(0) == 32, "R8 level top", lvl(0), 32);
    ticks(10);
    chk(lvl(0) == 32, "R8 level holds", lvl(0), 32);
  endtask

  task automatic t_gate_phase();
    pwm_req = 2'b00;
    ticks(1);
    chk(hs_gate == 0, "R2 request low", hs_gate, 0);
    pwm_req = 2'b11;
    wait_s();
    chk(hs_gate == 2'b01, "R2 ch0 on at strobe", hs_gate, 1);
    ticks(7);
    chk(hs_gate[1] == 0, "R10 ch1 not yet", hs_gate[1], 0);
    ticks(1);
    chk(hs_gate[1] == 1, "R10 ch1 half period", hs_gate[1], 1);
    pwm_req[0] = 1'b0;
    ticks(1);
    chk(hs_gate[0] == 0, "R2 request drop", hs_gate[0], 0);
    pwm_req[0] = 1'b1;
  endtask

  task automatic t_count_and_trip();
    wait_s();
    oc_cmp[0] = 1'b1;
    ticks(1);
    chk(hs_gate[0] == 0, "R3 pulse cut", hs_gate[0], 0);
    chk(hs_gate[1] == 1, "R10 ch1 untouched", hs_gate[1], 1);
    for (int i = 1; i <= 31; i++) wait_s();
    chk(hiccup[0] == 0, "R5 before limit", hiccup[0], 0);
    oc_cmp[0] = 1'b0;
    wait_s();
    chk(hiccup[0] == 0, "R6 clean period", hiccup[0], 0);
    oc_cmp[0] = 1'b1;
    for (int i = 33; i <= 63; i++) wait_s();
    chk(hiccup[0] == 0, "R6 count restarted", hiccup[0], 0);
    wait_s();
    chk(hiccup[0] == 1, "R5 hiccup at 32", hiccup[0], 1);
    chk(lvl(0) == 0, "R5 level dumped", lvl(0), 0);
    chk(out_en[0] == 0 && hs_gate[0] == 0, "R5 output off", {out_en[0], hs_gate[0]}, 0);
    chk(hiccup[1] == 0 && lvl(1) == 32, "R10 ch1 independent", hiccup[1], 0);
  endtask

  task automatic t_retry_loop();
    ticks(5);
    chk(lvl(0) == 0, "R8 discharge", lvl(0), 0);
    ticks(1);
    chk(lvl(0) == 0, "R8 discharge end", lvl(0), 0);
    ticks(2);
    chk(lvl(0) == 1, "R8 first step", lvl(0), 1);
    ticks(13);
    chk(out_en[0] == 0, "R8 below trip", out_en[0], 0);
    ticks(1);
    chk(out_en[0] == 1 && lvl(0) == 8, "R8 re-enable", lvl(0), 8);
    wait_s();
    chk(hs_gate[0] == 1, "R3 pulse starts in ramp", hs_gate[0], 1);
    ticks(1);
    chk(hs_gate[0] == 0, "R3 cut during ramp", hs_gate[0], 0);
    ticks(36);
    chk(hiccup[0] == 1, "R9 flag before top", hiccup[0], 1);
    ticks(1);
    chk(lvl(0) == 32 && hiccup[0] == 0, "R9 flag clears at top", hiccup[0], 0);
    for (int i = 1; i <= 31; i++) wait_s();
    chk(hiccup[0] == 0, "R7 counter held in ramp", hiccup[0], 0);
    wait_s();
    chk(hiccup[0] == 1, "R7 retry hiccup", hiccup[0], 1);
  endtask

  task automatic t_recover();
    oc_cmp[0] = 1'b0;
    ticks(70);
    chk(lvl(0) == 32 && hiccup[0] == 0, "R9 recovered", hiccup[0], 0);
    chk(out_en[0] == 1, "R9 enabled", out_en[0], 1);
    for (int i = 0; i < 40; i++) wait_s();
    chk(hiccup[0] == 0, "R9 stays clear", hiccup[0], 0);
  endtask

  task automatic t_ignore_off();
    pwm_req[0] = 1'b0;
    oc_cmp[0] = 1'b1;
    for (int i = 0; i < 36; i++) wait_s();
    chk(hiccup[0] == 0, "R4 no hiccup while off", hiccup[0], 0);
    chk(lvl(0) == 32 && hs_gate[0] == 0, "R4 level kept", lvl(0), 32);
    oc_cmp[0] = 1'b0;
    chk(hiccup[1] == 0 && lvl(1) == 32, "R10 ch1 final", lvl(1), 32);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_gate_phase();
    t_count_and_trip();
    t_retry_loop();
    t_recover();
    t_ignore_off();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule